// File: doc/BRIEF.md
# Reorder and Retire Buffer

This block keeps every dispatched instruction in a circular queue from dispatch until retirement. Execution pipelines finish out of order and report completion by entry index. The architectural state changes only at the oldest end of the queue, strictly in program order. At dispatch the block allocates the slot at the tail and returns its index. The slot is tagged with the address of the following instruction, the destination register, and two flags that say whether the instruction writes a register and whether it writes memory.

Each cycle the block inspects the oldest one or two entries. Any entry that has finished, with every older entry also finished, retires. Retiring raises the register and memory write-back enables for that lane and advances the software-visible PC. Fetch and dispatch never move that PC, so it always holds the address that follows the last retired instruction. A flush empties the queue in one cycle and discards every in-flight entry.

Top module: `rob_top`

## Requirements
- R1: After synchronous reset, rob_empty is 1, rob_full is 0, disp_ready is 1, disp_idx is 0, both retire lanes are invalid and arch_pc equals RESET_PC.
- R2: A dispatch is accepted when disp_valid is 1, the queue is not full and flush is 0. The slot it takes is the value of disp_idx in that cycle. disp_idx then steps by one.
- R3: With DEPTH entries occupied, rob_full is 1 and disp_ready is 0. A dispatch attempted while full is dropped: it never retires and never changes arch_pc.
- R4: Two completion ports, cmpN_valid with cmpN_idx, each mark the addressed entry finished. Both may be used in the same cycle.
- R5: A finished entry never retires while any older entry is unfinished.
- R6: At most two entries retire per cycle, lane 0 being the oldest. Lane 1 is valid only together with lane 0.
- R7: A retirement shows up on the retire lane outputs in the cycle after the entry's completion was sampled. retN_reg_we and retN_mem_we repeat the entry's dispatch flags, and retN_dest repeats its destination.
- R8: arch_pc changes only on retirement. It takes the next-PC tag of the youngest entry retired in that cycle, and dispatch leaves it unchanged.
- R9: A flush empties the queue in one cycle. It suppresses retirement in that cycle and resets disp_idx to 0. Entries present before the flush never retire, and arch_pc is kept.
- R10: Slot indices wrap from DEPTH-1 to 0 for both allocation and retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_pc_next | input | PC_W | Address following the dispatched instruction |
| disp_dest | input | REG_W | Destination register number |
| disp_reg_we | input | 1 | Instruction writes a register |
| disp_mem_we | input | 1 | Instruction writes memory |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_idx | output | IDX_W | Slot the next dispatch will occupy |
| cmp0_valid | input | 1 | Completion port 0 strobe |
| cmp0_idx | input | IDX_W | Completion port 0 slot |
| cmp1_valid | input | 1 | Completion port 1 strobe |
| cmp1_idx | input | IDX_W | Completion port 1 slot |
| ret0_valid | output | 1 | Oldest lane retired |
| ret0_reg_we | output | 1 | Lane 0 register write enable |
| ret0_mem_we | output | 1 | Lane 0 memory write enable |
| ret0_dest | output | REG_W | Lane 0 destination |
| ret1_valid | output | 1 | Second lane retired |
| ret1_reg_we | output | 1 | Lane 1 register write enable |
| ret1_mem_we | output | 1 | Lane 1 memory write enable |
| ret1_dest | output | REG_W | Lane 1 destination |
| arch_pc | output | PC_W | Software-visible PC |
| rob_full | output | 1 | All slots occupied |
| rob_empty | output | 1 | No slot occupied |

## Verification
The hardest state to reach from the ports is a flush that lands in the same cycle as a retirement that is ready to fire. The stimulus arranges this by completing the head entry and raising flush on the very next edge, so the retire decision and the flush are evaluated together. The full-queue wrap is also awkward to reach. The bench first leaves the pointers at a non-zero offset and then fills all sixteen slots, so allocation crosses index zero. It pushes one extra dispatch while full, then drains the queue in completion pairs.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // write-back classification carried with every entry
  typedef struct packed {
    logic reg_we;
    logic mem_we;
  } wb_kind_t;

  localparam int WB_KIND_W = 2;

endpackage

// File: rtl/rob_entry_ram.sv
// Payload store: one write port at the tail, two reads at the head pair.
module rob_entry_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 39,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr0,
  output logic [W-1:0]     rdata0,
  input  logic [IDX_W-1:0] raddr1,
  output logic [W-1:0]     rdata1
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/rob_done_bits.sv
// Per-slot finished flags; multi-port set, cleared on allocation and flush.
module rob_done_bits #(
  parameter int DEPTH   = 16,
  parameter int NUM_CMP = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic [NUM_CMP-1:0]       cmp_valid,
  input  logic [NUM_CMP*IDX_W-1:0] cmp_idx,
  output logic [DEPTH-1:0]         done
);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      done <= '0;
    end else begin
      if (alloc_en) done[alloc_idx] <= 1'b0;
      for (int k = 0; k < NUM_CMP; k++) begin
        if (cmp_valid[k]) done[cmp_idx[k*IDX_W +: IDX_W]] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rob_ptrs.sv
// Head, tail and occupancy with modulo-DEPTH wrap.
module rob_ptrs #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [1:0]       ret_cnt,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] head_nx1,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);

  function automatic logic [IDX_W-1:0] adv(input logic [IDX_W-1:0] p,
                                           input logic [1:0] n);
    logic [IDX_W+1:0] s;
    s = {2'b00, p} + (IDX_W + 2)'(n);
    if (s >= (IDX_W + 2)'(DEPTH)) s = s - (IDX_W + 2)'(DEPTH);
    return s[IDX_W-1:0];
  endfunction

  assign head_nx1 = adv(head, 2'd1);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= adv(head, ret_cnt);
      if (alloc_en) tail <= adv(tail, 2'd1);
      count <= count + CNT_W'(alloc_en) - CNT_W'(ret_cnt);
    end
  end

endmodule

// File: rtl/rob_retire.sv
// In-order two-lane retirement decision with registered write-back outputs.
module rob_retire #(
  parameter int DEPTH              = 16,
  parameter int PC_W               = 32,
  parameter int REG_W              = 5,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  head_nx1,
  input  logic [CNT_W-1:0]  count,
  input  logic [DEPTH-1:0]  done,
  input  logic [PC_W-1:0]   pc0,
  input  logic [REG_W-1:0]  dest0,
  input  rob_pkg::wb_kind_t kind0,
  input  logic [PC_W-1:0]   pc1,
  input  logic [REG_W-1:0]  dest1,
  input  rob_pkg::wb_kind_t kind1,
  output logic [1:0]        ret_cnt,
  output logic              ret0_valid,
  output logic              ret0_reg_we,
  output logic              ret0_mem_we,
  output logic [REG_W-1:0]  ret0_dest,
  output logic              ret1_valid,
  output logic              ret1_reg_we,
  output logic              ret1_mem_we,
  output logic [REG_W-1:0]  ret1_dest,
  output logic [PC_W-1:0]   arch_pc
);

  logic go0, go1;

  always_comb begin
    go0 = !flush && (count != '0) && done[head];
    go1 = go0 && (count >= CNT_W'(2)) && done[head_nx1];
    ret_cnt = {1'b0, go0} + {1'b0, go1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ret0_valid  <= 1'b0;
      ret0_reg_we <= 1'b0;
      ret0_mem_we <= 1'b0;
      ret0_dest   <= '0;
      ret1_valid  <= 1'b0;
      ret1_reg_we <= 1'b0;
      ret1_mem_we <= 1'b0;
      ret1_dest   <= '0;
      arch_pc     <= RESET_PC;
    end else begin
      ret0_valid  <= go0;
      ret0_reg_we <= go0 && kind0.reg_we;
      ret0_mem_we <= go0 && kind0.mem_we;
      ret0_dest   <= dest0;
      ret1_valid  <= go1;
      ret1_reg_we <= go1 && kind1.reg_we;
      ret1_mem_we <= go1 && kind1.mem_we;
      ret1_dest   <= dest1;
      if (go1)      arch_pc <= pc1;
      else if (go0) arch_pc <= pc0;
    end
  end

endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int DEPTH                 = 16,
  parameter int PC_W                  = 32,
  parameter int REG_W                 = 5,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             disp_valid,
  input  logic [PC_W-1:0]  disp_pc_next,
  input  logic [REG_W-1:0] disp_dest,
  input  logic             disp_reg_we,
  input  logic             disp_mem_we,
  output logic             disp_ready,
  output logic [IDX_W-1:0] disp_idx,
  input  logic             cmp0_valid,
  input  logic [IDX_W-1:0] cmp0_idx,
  input  logic             cmp1_valid,
  input  logic [IDX_W-1:0] cmp1_idx,
  output logic             ret0_valid,
  output logic             ret0_reg_we,
  output logic             ret0_mem_we,
  output logic [REG_W-1:0] ret0_dest,
  output logic             ret1_valid,
  output logic             ret1_reg_we,
  output logic             ret1_mem_we,
  output logic [REG_W-1:0] ret1_dest,
  output logic [PC_W-1:0]  arch_pc,
  output logic             rob_full,
  output logic             rob_empty
);

  localparam int PAY_W = PC_W + REG_W + rob_pkg::WB_KIND_W;

  logic [IDX_W-1:0]  head, head_nx1, tail;
  logic [CNT_W-1:0]  occ_count;
  logic [DEPTH-1:0]  done;
  logic [1:0]        ret_cnt;
  logic              alloc_en;
  logic [PAY_W-1:0]  wpay, rpay0, rpay1;
  rob_pkg::wb_kind_t wkind, kind0, kind1;
  logic [PC_W-1:0]   pc0, pc1;
  logic [REG_W-1:0]  dest0, dest1;

  assign rob_full   = (occ_count == CNT_W'(DEPTH));
  assign rob_empty  = (occ_count == '0);
  assign disp_ready = !rob_full;
  assign disp_idx   = tail;
  assign alloc_en   = disp_valid && !rob_full && !flush;

  assign wkind.reg_we = disp_reg_we;
  assign wkind.mem_we = disp_mem_we;
  assign wpay = {disp_pc_next, disp_dest, wkind};
  assign {pc0, dest0, kind0} = rpay0;
  assign {pc1, dest1, kind1} = rpay1;

  rob_entry_ram #(.DEPTH(DEPTH), .W(PAY_W)) u_ram (
    .clk(clk), .we(alloc_en), .waddr(tail), .wdata(wpay),
    .raddr0(head), .rdata0(rpay0), .raddr1(head_nx1), .rdata1(rpay1)
  );

  rob_done_bits #(.DEPTH(DEPTH), .NUM_CMP(2)) u_done (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_en(alloc_en), .alloc_idx(tail),
    .cmp_valid({cmp1_valid, cmp0_valid}), .cmp_idx({cmp1_idx, cmp0_idx}),
    .done(done)
  );

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush), .alloc_en(alloc_en),
    .ret_cnt(ret_cnt), .head(head), .head_nx1(head_nx1), .tail(tail),
    .count(occ_count)
  );

  rob_retire #(.DEPTH(DEPTH), .PC_W(PC_W), .REG_W(REG_W), .RESET_PC(RESET_PC)) u_ret (
    .clk(clk), .rst(rst), .flush(flush),
    .head(head), .head_nx1(head_nx1), .count(occ_count), .done(done),
    .pc0(pc0), .dest0(dest0), .kind0(kind0),
    .pc1(pc1), .dest1(dest1), .kind1(kind1),
    .ret_cnt(ret_cnt),
    .ret0_valid(ret0_valid), .ret0_reg_we(ret0_reg_we),
    .ret0_mem_we(ret0_mem_we), .ret0_dest(ret0_dest),
    .ret1_valid(ret1_valid), .ret1_reg_we(ret1_reg_we),
    .ret1_mem_we(ret1_mem_we), .ret1_dest(ret1_dest),
    .arch_pc(arch_pc)
  );

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH  = 16,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             disp_valid,
  input logic             rob_full,
  input logic             rob_empty,
  input logic             ret0_valid,
  input logic             ret1_valid,
  input logic [PC_W-1:0]  arch_pc,
  input logic [IDX_W-1:0] disp_idx,
  input logic [CNT_W-1:0] count
);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  p_full_no_alloc_r3: assert property (@(posedge clk) disable iff (rst)
    (rob_full && disp_valid) |=> (count <= $past(count)));

  p_lane_order_r6: assert property (@(posedge clk) disable iff (rst)
    ret1_valid |-> ret0_valid);

  p_pair_needs_two_r5: assert property (@(posedge clk) disable iff (rst)
    ret1_valid |-> ($past(count) >= CNT_W'(2)));

  p_pc_moves_on_retire_r8: assert property (@(posedge clk) disable iff (rst)
    !ret0_valid |-> $stable(arch_pc));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rob_empty && !ret0_valid && disp_idx == '0));

endmodule

bind rob_top rob_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) i_chk (
  .clk(clk), .rst(rst), .flush(flush), .disp_valid(disp_valid),
  .rob_full(rob_full), .rob_empty(rob_empty),
  .ret0_valid(ret0_valid), .ret1_valid(ret1_valid),
  .arch_pc(arch_pc), .disp_idx(disp_idx), .count(occ_count)
);

// File: tb/test_rob_top.sv
module test_rob_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic disp_valid = 1'b0;
  logic [31:0] disp_pc_next = '0;
  logic [4:0] disp_dest = '0;
  logic disp_reg_we = 1'b0, disp_mem_we = 1'b0;
  logic disp_ready;
  logic [3:0] disp_idx;
  logic cmp0_valid = 1'b0, cmp1_valid = 1'b0;
  logic [3:0] cmp0_idx = '0, cmp1_idx = '0;
  logic ret0_valid, ret0_reg_we, ret0_mem_we, ret1_valid, ret1_reg_we, ret1_mem_we;
  logic [4:0] ret0_dest, ret1_dest;
  logic [31:0] arch_pc;
  logic rob_full, rob_empty;

  int checks = 0;
  int errors = 0;
  int ret_total = 0;
  logic [3:0] slots [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_top i_rob_top (.*);

  always @(negedge clk) begin
    if (!rst) ret_total = ret_total + int'(ret0_valid) + int'(ret1_valid);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic dispatch(input logic [31:0] npc, input logic [4:0] d,
                          input logic rw, input logic mw, output logic [3:0] idx);
    disp_valid = 1'b1; disp_pc_next = npc; disp_dest = d;
    disp_reg_we = rw; disp_mem_we = mw;
    idx = disp_idx;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic complete(input logic v0, input logic [3:0] i0,
                          input logic v1, input logic [3:0] i1);
    cmp0_valid = v0; cmp0_idx = i0; cmp1_valid = v1; cmp1_idx = i1;
    @(negedge clk);
    cmp0_valid = 1'b0; cmp1_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 empty", 32'(rob_empty), 32'd1);
    check("R1 full", 32'(rob_full), 32'd0);
    check("R1 ready", 32'(disp_ready), 32'd1);
    check("R1 idx", 32'(disp_idx), 32'd0);
    check("R1 ret0", 32'(ret0_valid), 32'd0);
    check("R1 pc", arch_pc, 32'h100);
  endtask

  task automatic t_inorder;
    logic [3:0] a, b, c;
    dispatch(32'h104, 5'd1, 1'b1, 1'b0, a);
    dispatch(32'h108, 5'd2, 1'b1, 1'b0, b);
    dispatch(32'h10c, 5'd3, 1'b1, 1'b0, c);
    check("R2 idx a", 32'(a), 32'd0);
    check("R2 idx c", 32'(c), 32'd2);
    check("R8 pc kept on dispatch", arch_pc, 32'h100);
    complete(1'b1, c, 1'b1, b);   // R4 two ports same cycle
    for (int k = 0; k < 3; k++) begin
      check("R5 younger waits", 32'(ret0_valid), 32'd0);
      @(negedge clk);
    end
    complete(1'b1, a, 1'b0, 4'd0);
    @(negedge clk);
    check("R6 lane0", 32'(ret0_valid), 32'd1);
    check("R6 lane0 dest", 32'(ret0_dest), 32'd1);
    check("R6 lane1", 32'(ret1_valid), 32'd1);
    check("R4 lane1 dest", 32'(ret1_dest), 32'd2);
    check("R8 pc pair", arch_pc, 32'h108);
    @(negedge clk);
    check("R6 third dest", 32'(ret0_dest), 32'd3);
    check("R6 lane1 off", 32'(ret1_valid), 32'd0);
    check("R8 pc single", arch_pc, 32'h10c);
    @(negedge clk);
    check("R5 drained", 32'(rob_empty), 32'd1);
  endtask

  task automatic t_kinds;
    logic [3:0] s, r;
    dispatch(32'h200, 5'd7, 1'b0, 1'b1, s);
    dispatch(32'h204, 5'd9, 1'b1, 1'b0, r);
    complete(1'b1, s, 1'b1, r);
    @(negedge clk);
    check("R7 store mem_we", 32'(ret0_mem_we), 32'd1);
    check("R7 store reg_we", 32'(ret0_reg_we), 32'd0);
    check("R7 alu reg_we", 32'(ret1_reg_we), 32'd1);
    check("R7 alu mem_we", 32'(ret1_mem_we), 32'd0);
    check("R7 alu dest", 32'(ret1_dest), 32'd9);
    check("R8 pc", arch_pc, 32'h204);
  endtask

  task automatic t_full;
    logic [3:0] junk;
    int snap;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] tmp;
      dispatch(32'h300 + 32'(4*k), 5'(k), 1'b1, 1'b0, tmp);
      slots[k] = tmp;
    end
    check("R10 first slot", 32'(slots[0]), 32'd5);
    check("R10 wrapped slot", 32'(slots[11]), 32'd0);
    check("R3 full", 32'(rob_full), 32'd1);
    check("R3 ready", 32'(disp_ready), 32'd0);
    snap = ret_total;
    dispatch(32'hdead0, 5'd31, 1'b1, 1'b1, junk);
    check("R3 still full", 32'(rob_full), 32'd1);
    for (int k = 0; k < 16; k += 2) complete(1'b1, slots[k], 1'b1, slots[k+1]);
    repeat (3) @(negedge clk);
    check("R3 retire count", 32'(ret_total - snap), 32'd16);
    check("R3 pc after drain", arch_pc, 32'h33c);
    check("R10 empty after wrap", 32'(rob_empty), 32'd1);
  endtask

  task automatic t_flush;
    logic [3:0] a, b, n;
    int snap;
    dispatch(32'h400, 5'd4, 1'b1, 1'b0, a);
    dispatch(32'h404, 5'd5, 1'b1, 1'b0, b);
    complete(1'b1, a, 1'b1, b);
    flush = 1'b1;
    snap = ret_total;
    @(negedge clk);
    flush = 1'b0;
    check("R9 no retire", 32'(ret0_valid), 32'd0);
    check("R9 empty", 32'(rob_empty), 32'd1);
    check("R9 idx", 32'(disp_idx), 32'd0);
    check("R9 pc kept", arch_pc, 32'h33c);
    repeat (2) @(negedge clk);
    check("R9 discarded", 32'(ret_total - snap), 32'd0);
    dispatch(32'h500, 5'd6, 1'b1, 1'b0, n);
    check("R9 restart slot", 32'(n), 32'd0);
    complete(1'b1, n, 1'b0, 4'd0);
    @(negedge clk);
    check("R9 new retires", 32'(ret0_dest), 32'd6);
    check("R9 new pc", arch_pc, 32'h500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_inorder();
    t_kinds();
    t_full();
    t_flush();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule